// File: doc/BRIEF.md
# Interleaved Multi-Bank Line Fetch Controller

This block fetches a short cache line from a word-addressed memory that is split into a power-of-two number of independent banks. The low address bits pick the bank and the remaining bits pick the row inside it. Each bank holds its own latched row address, its own data output and its own accept and release controls. A bank spends a fixed number of cycles receiving the address, a fixed number accessing its array and a fixed number sending the word back. Because several banks can be in flight together, a line whose words fall in different banks costs roughly one bank access instead of one access per word.

A client pulses `start` with a first word address and a stride. The controller then issues one word request per cycle, to the addresses first, first+stride, first+2·stride and so on, wrapping modulo the address space. If the target bank of the next request is still occupied, the controller waits for it. The words come back on a single shared return bus at no more than one per cycle, strictly in request order, and each word carries its sequence number. A one-cycle `done` pulse marks the last word of the line.

Each bank is a behavioural timing model. The word it returns is a fixed function of the word address, so that bank selection and row decoding can be observed at the ports.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: `start` is captured only when `busy` is low. `busy` rises in the cycle after the capturing edge and falls in the same cycle in which `done` is high. While `busy` is low and `done` is low, `ret_valid` stays low.
- R2: Word address A is served by bank A mod NUM_BANKS at row A div NUM_BANKS. The returned word equals DATA_KEY XOR A, with A zero-extended to WORD_W bits (default DATA_KEY = 32'hC3A5_0000).
- R3: A bank holds a request for T_ADDR+T_ACC+T_RET edges (L, default 80) before its word is ready. When all banks are free, the first word appears on the return bus L+2 edges after the capturing edge.
- R4: Request k of a line (k = 0..LINE_WORDS-1) targets address start_addr + k·stride modulo 2^ADDR_W. Requests leave in order of k, at most one per cycle.
- R5: A bank accepts no request from the edge that accepts one until the edge that passes its word to the return bus, and it can accept again one edge later. The issue side stalls meanwhile. A line whose words all hit one bank (for example stride 0 or stride 4) takes LINE_WORDS·(L+2) edges from the capturing edge to `done`. Stride 2 from address 0 with 4 banks takes 2·(L+2)+1 edges.
- R6: Words leave the return bus in request order, at most one per cycle. `ret_seq` carries k on the word of request k.
- R7: `done` is high for exactly one cycle, together with `ret_valid` of the last word (ret_seq = LINE_WORDS-1).
- R8: When all words of a line fall in distinct banks, for example stride 1 or stride 3 over 4 banks (stride 3 visits banks 0, 3, 2, 1 from address 0), `done` arrives L+LINE_WORDS+1 edges after the capturing edge. By default that is 85 edges, well under the 320 a one-word-at-a-time fetch would take.
- R9: A `start` pulse while `busy` is high has no effect. The running line returns exactly LINE_WORDS words, and no further line follows.
- R10: After reset, `busy`, `ret_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a line fetch (taken only when idle) |
| start_addr | input | ADDR_W | Word address of request 0 |
| stride | input | ADDR_W | Address step between requests |
| busy | output | 1 | A line fetch is in progress |
| ret_valid | output | 1 | A word is on the return bus |
| ret_data | output | WORD_W | Returned word |
| ret_seq | output | log2(LINE_WORDS) | Request number of the returned word |
| done | output | 1 | One-cycle pulse with the last word |

## Verification
With free banks, request k reaches its bank k+1 edges after the capturing edge. Its word is ready L edges later and is on the return bus one edge after that. A bank it conflicts with delays it by a further L+2 edges per conflict. The bench keeps a behavioural model of bank occupancy, countdowns and an ordered queue of pending banks. The model steps on each rising edge using only stimulus values, and its expected outputs are compared with the design in the middle of every cycle. In addition, the cycle distances from the capturing edge to the first word and to `done` are measured for each stride pattern and compared with the closed-form counts given in R3, R5 and R8.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   // Life cycle of one bank access
   typedef enum logic [2:0] {
      BK_IDLE,
      BK_ADDR,
      BK_ARRAY,
      BK_XFER,
      BK_HOLD
   } bank_ph_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
   import ilv_pkg::*;
#(
   parameter int BANK_ID   = 0,
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12,
   parameter int WORD_W    = 32,
   parameter int T_ADDR    = 10,
   parameter int T_ACC     = 60,
   parameter int T_RET     = 10,
   parameter logic [WORD_W-1:0] DATA_KEY = '0
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 acc_req,
   input  logic [ADDR_W-$clog2(NUM_BANKS)-1:0]  acc_row,
   input  logic                                 take,
   output logic                                 busy,
   output logic                                 rdy,
   output logic [WORD_W-1:0]                    rdata
);
   localparam int BANK_BITS = $clog2(NUM_BANKS);
   localparam int ROW_W     = ADDR_W - BANK_BITS;
   localparam int TMAX      = (T_ACC > T_ADDR) ? ((T_ACC > T_RET) ? T_ACC : T_RET)
                                               : ((T_ADDR > T_RET) ? T_ADDR : T_RET);
   localparam int TC_W      = $clog2(TMAX + 1);

   bank_ph_e          ph;
   logic [TC_W-1:0]   tcnt;
   logic [ROW_W-1:0]  row_q;
   logic              tdone;

   assign tdone = (tcnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph    <= BK_IDLE;
         tcnt  <= '0;
         row_q <= '0;
         rdata <= '0;
      end else begin
         unique case (ph)
            BK_IDLE:
               if (acc_req) begin
                  ph    <= BK_ADDR;
                  tcnt  <= TC_W'(T_ADDR - 1);
                  row_q <= acc_row;
               end
            BK_ADDR:
               if (tdone) begin
                  ph   <= BK_ARRAY;
                  tcnt <= TC_W'(T_ACC - 1);
               end else tcnt <= tcnt - 1'b1;
            BK_ARRAY:
               if (tdone) begin
                  ph    <= BK_XFER;
                  tcnt  <= TC_W'(T_RET - 1);
                  rdata <= DATA_KEY ^ WORD_W'({row_q, BANK_BITS'(BANK_ID)});
               end else tcnt <= tcnt - 1'b1;
            BK_XFER:
               if (tdone) ph <= BK_HOLD;
               else       tcnt <= tcnt - 1'b1;
            BK_HOLD:
               if (take) ph <= BK_IDLE;
            default: ph <= BK_IDLE;
         endcase
      end
   end

   assign busy = (ph != BK_IDLE);
   assign rdy  = (ph == BK_HOLD);
endmodule

// File: rtl/ilv_issue.sv
module ilv_issue #(
   parameter int NUM_BANKS  = 4,
   parameter int ADDR_W     = 12,
   parameter int LINE_WORDS = 4
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 load,
   input  logic [ADDR_W-1:0]                    start_addr,
   input  logic [ADDR_W-1:0]                    stride,
   input  logic [NUM_BANKS-1:0]                 bank_busy,
   output logic                                 fire,
   output logic [$clog2(NUM_BANKS)-1:0]         iss_bank,
   output logic [ADDR_W-$clog2(NUM_BANKS)-1:0]  iss_row,
   output logic [NUM_BANKS-1:0]                 acc_req
);
   localparam int BANK_BITS = $clog2(NUM_BANKS);
   localparam int CNT_W     = $clog2(LINE_WORDS + 1);

   logic [ADDR_W-1:0] cur_addr, stride_q;
   logic [CNT_W-1:0]  n_iss;
   logic              run;

   assign iss_bank = cur_addr[BANK_BITS-1:0];
   assign iss_row  = cur_addr[ADDR_W-1:BANK_BITS];
   assign fire     = run && !bank_busy[iss_bank];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         stride_q <= '0;
         n_iss    <= '0;
         run      <= 1'b0;
      end else if (load) begin
         cur_addr <= start_addr;
         stride_q <= stride;
         n_iss    <= '0;
         run      <= 1'b1;
      end else if (fire) begin
         cur_addr <= cur_addr + stride_q;
         n_iss    <= n_iss + 1'b1;
         if (n_iss == CNT_W'(LINE_WORDS - 1)) run <= 1'b0;
      end
   end

   for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_sel
      assign acc_req[gb] = fire && (iss_bank == BANK_BITS'(gb));
   end
endmodule

// File: rtl/ilv_retq.sv
module ilv_retq #(
   parameter int NUM_BANKS  = 4,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  load,
   input  logic                                  push,
   input  logic [$clog2(NUM_BANKS)-1:0]          push_bank,
   input  logic [NUM_BANKS-1:0]                  bank_rdy,
   input  logic [NUM_BANKS-1:0][WORD_W-1:0]      bank_data,
   output logic [NUM_BANKS-1:0]                  take,
   output logic                                  finish,
   output logic                                  ret_valid,
   output logic [WORD_W-1:0]                     ret_data,
   output logic [$clog2(LINE_WORDS)-1:0]         ret_seq,
   output logic                                  done
);
   localparam int BANK_BITS = $clog2(NUM_BANKS);
   localparam int SEQ_W     = $clog2(LINE_WORDS);
   localparam int CNT_W     = $clog2(LINE_WORDS + 1);

   logic [BANK_BITS-1:0] order_q [LINE_WORDS];
   logic [CNT_W-1:0]     wr_cnt, rd_cnt;
   logic [BANK_BITS-1:0] head_bank;
   logic                 pop;

   assign head_bank = order_q[rd_cnt[SEQ_W-1:0]];
   assign pop       = (rd_cnt != wr_cnt) && bank_rdy[head_bank];
   assign finish    = pop && (rd_cnt == CNT_W'(LINE_WORDS - 1));

   always_ff @(posedge clk) begin
      if (push) order_q[wr_cnt[SEQ_W-1:0]] <= push_bank;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_cnt    <= '0;
         rd_cnt    <= '0;
         ret_valid <= 1'b0;
         ret_data  <= '0;
         ret_seq   <= '0;
         done      <= 1'b0;
      end else begin
         ret_valid <= pop;
         done      <= finish;
         if (pop) begin
            ret_data <= bank_data[head_bank];
            ret_seq  <= rd_cnt[SEQ_W-1:0];
         end
         if (load) begin
            wr_cnt <= '0;
            rd_cnt <= '0;
         end else begin
            if (push) wr_cnt <= wr_cnt + 1'b1;
            if (pop)  rd_cnt <= rd_cnt + 1'b1;
         end
      end
   end

   for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_take
      assign take[gb] = pop && (head_bank == BANK_BITS'(gb));
   end
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
   parameter int NUM_BANKS  = 4,
   parameter int ADDR_W     = 12,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int T_ADDR     = 10,
   parameter int T_ACC      = 60,
   parameter int T_RET      = 10,
   parameter logic [WORD_W-1:0] DATA_KEY = WORD_W'(32'hC3A5_0000)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic [ADDR_W-1:0]              start_addr,
   input  logic [ADDR_W-1:0]              stride,
   output logic                           busy,
   output logic                           ret_valid,
   output logic [WORD_W-1:0]              ret_data,
   output logic [$clog2(LINE_WORDS)-1:0]  ret_seq,
   output logic                           done
);
   localparam int BANK_BITS = $clog2(NUM_BANKS);
   localparam int ROW_W     = ADDR_W - BANK_BITS;

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (T_ADDR < 1 || T_ACC < 1 || T_RET < 1) begin : g_bad_lat
      $error("each bank phase needs at least one cycle");
   end
   if (WORD_W < ADDR_W || ROW_W < 1) begin : g_bad_width
      $error("WORD_W must cover ADDR_W and ADDR_W must exceed the bank bits");
   end

   logic                               active, load, fire, finish;
   logic [BANK_BITS-1:0]               iss_bank;
   logic [ROW_W-1:0]                   iss_row;
   logic [NUM_BANKS-1:0]               acc_req, bank_busy, bank_rdy, take_vec;
   logic [NUM_BANKS-1:0][WORD_W-1:0]   bank_data;

   assign load = start && !active;
   assign busy = active;

   always_ff @(posedge clk) begin
      if (!rst_n)      active <= 1'b0;
      else if (load)   active <= 1'b1;
      else if (finish) active <= 1'b0;
   end

   ilv_issue #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_issue (
      .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr), .stride(stride),
      .bank_busy(bank_busy), .fire(fire), .iss_bank(iss_bank), .iss_row(iss_row),
      .acc_req(acc_req));

   for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      ilv_bank #(
         .BANK_ID(gb), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
         .T_ADDR(T_ADDR), .T_ACC(T_ACC), .T_RET(T_RET), .DATA_KEY(DATA_KEY)
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .acc_req(acc_req[gb]), .acc_row(iss_row),
         .take(take_vec[gb]), .busy(bank_busy[gb]), .rdy(bank_rdy[gb]),
         .rdata(bank_data[gb]));
   end

   ilv_retq #(.NUM_BANKS(NUM_BANKS), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_retq (
      .clk(clk), .rst_n(rst_n), .load(load), .push(fire), .push_bank(iss_bank),
      .bank_rdy(bank_rdy), .bank_data(bank_data), .take(take_vec), .finish(finish),
      .ret_valid(ret_valid), .ret_data(ret_data), .ret_seq(ret_seq), .done(done));
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
module ilv_mem_ctrl_chk #(
   parameter int NUM_BANKS = 4,
   parameter int SEQ_W     = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy,
   input logic                 ret_valid,
   input logic [SEQ_W-1:0]     ret_seq,
   input logic                 done,
   input logic [NUM_BANKS-1:0] acc_req,
   input logic [NUM_BANKS-1:0] bank_busy,
   input logic [NUM_BANKS-1:0] take
);
   logic [SEQ_W-1:0] seq_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)         seq_cnt <= '0;
      else if (done)      seq_cnt <= '0;
      else if (ret_valid) seq_cnt <= seq_cnt + 1'b1;
   end

   // R7
   done_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ret_valid);
   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R1
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R1
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done) |-> !ret_valid);
   // R5
   no_busy_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req & bank_busy) == '0);
   // R4
   single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(acc_req));
   // R6
   single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take));
   // R5
   take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take & ~bank_busy) == '0);
   // R6
   seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> (ret_seq == seq_cnt));
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .SEQ_W($clog2(LINE_WORDS))) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .ret_valid(ret_valid), .ret_seq(ret_seq),
   .done(done), .acc_req(acc_req), .bank_busy(bank_busy), .take(take_vec));

// File: tb/sim_ilv_mem_ctrl.sv
`timescale 1ns/1ps
module sim_ilv_mem_ctrl;
   localparam int NB = 4, AW = 12, WW = 32, LINE = 4;
   localparam int TA = 10, TC = 60, TR = 10;
   localparam int L  = TA + TC + TR;
   localparam logic [WW-1:0] KEY = 32'hC3A5_0000;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [AW-1:0] start_addr = '0, stride = '0;
   logic busy, ret_valid, done;
   logic [WW-1:0] ret_data;
   logic [1:0] ret_seq;

   int total = 0, bad = 0, cyc = 0;
   bit finished = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ilv_mem_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .WORD_W(WW), .LINE_WORDS(LINE),
      .T_ADDR(TA), .T_ACC(TC), .T_RET(TR), .DATA_KEY(KEY)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .stride(stride),
      .busy(busy), .ret_valid(ret_valid), .ret_data(ret_data), .ret_seq(ret_seq), .done(done));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // Behavioural reference model, stepped on each rising edge
   int          m_left [NB];
   bit          m_busy [NB], m_rdy [NB];
   logic [AW-1:0] m_waddr [NB];
   bit          m_active;
   logic [AW-1:0] m_addr, m_stride;
   int          m_niss, m_head;
   int          hq [$];
   bit          e_rv, e_done;
   logic [WW-1:0] e_data;
   int          e_seq;

   always @(posedge clk) begin
      bit pre_active, fire, pop;
      int fb, pb;
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin m_busy[b] = 0; m_rdy[b] = 0; m_left[b] = 0; end
         m_active = 0; m_niss = 0; m_head = 0; hq.delete();
         e_rv = 0; e_done = 0; e_seq = 0; e_data = '0;
      end else begin
         pre_active = m_active;
         fb   = int'(m_addr % NB);
         fire = m_active && (m_niss < LINE) && !m_busy[fb];
         pop  = m_active && (hq.size() > 0) && m_rdy[hq[0]];
         e_rv = 0; e_done = 0;
         for (int b = 0; b < NB; b++)
            if (m_busy[b] && !m_rdy[b]) begin
               m_left[b]--;
               if (m_left[b] == 0) m_rdy[b] = 1;
            end
         if (pop) begin
            pb = hq.pop_front();
            e_rv = 1; e_data = KEY ^ WW'(m_waddr[pb]); e_seq = m_head; m_head++;
            m_busy[pb] = 0; m_rdy[pb] = 0;
            if (m_head == LINE) begin e_done = 1; m_active = 0; end
         end
         if (fire) begin
            m_busy[fb] = 1; m_rdy[fb] = 0; m_left[fb] = L; m_waddr[fb] = m_addr;
            hq.push_back(fb); m_addr = m_addr + m_stride; m_niss++;
         end
         if (start && !pre_active) begin
            m_active = 1; m_addr = start_addr; m_stride = stride; m_niss = 0; m_head = 0;
         end
      end
   end

   // Per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(busy == m_active, "R1", "busy", busy, m_active);
         chk(ret_valid == e_rv, "R6", "ret_valid", ret_valid, e_rv);
         chk(done == e_done, "R7", "done", done, e_done);
         if (e_rv && ret_valid) begin
            chk(ret_data == e_data, "R2", "ret_data (R4 address order)", ret_data, e_data);
            chk(int'(ret_seq) == e_seq, "R6", "ret_seq", ret_seq, e_seq);
         end
      end
   end

   task automatic run_line(input logic [AW-1:0] a, input logic [AW-1:0] s, input int poke,
                           output int lat_first, output int lat_done, output int words);
      int t0;
      @(negedge clk); start = 1; start_addr = a; stride = s;
      @(negedge clk); start = 0; t0 = cyc;
      lat_first = -1; lat_done = -1; words = 0;
      for (int i = 0; i < 2000; i++) begin
         if (i == poke) begin start = 1; start_addr = a + 12'd333; stride = 12'd7; end
         else start = 0;
         @(negedge clk);
         if (ret_valid) begin
            words++;
            if (ret_seq == 0 && lat_first < 0) lat_first = cyc - t0;
         end
         if (done) begin lat_done = cyc - t0; break; end
      end
      start = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int lf, ld, nw, seen;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(busy == 0, "R10", "busy after reset", busy, 0);
      chk(ret_valid == 0, "R10", "ret_valid after reset", ret_valid, 0);
      chk(done == 0, "R10", "done after reset", done, 0);
      rst_n = 1;
      @(negedge clk);

      // stride 1: distinct banks
      run_line(12'd0, 12'd1, -1, lf, ld, nw);
      chk(lf == L + 2, "R3", "first word latency", lf, L + 2);
      chk(ld == L + LINE + 1, "R8", "line latency stride 1", ld, L + LINE + 1);
      chk(ld < 320, "R8", "beats serial fetch", ld, 320);
      chk(nw == LINE, "R6", "word count", nw, LINE);

      // stride 3 from 0: banks 0,3,2,1, back-to-back start after done (R1)
      run_line(12'd0, 12'd3, -1, lf, ld, nw);
      chk(ld == L + LINE + 1, "R8", "line latency stride 3", ld, L + LINE + 1);
      chk(lf == L + 2, "R3", "first word stride 3", lf, L + 2);

      // stride 3 from odd address
      run_line(12'd5, 12'd3, -1, lf, ld, nw);
      chk(ld == L + LINE + 1, "R8", "line latency stride 3 @5", ld, L + LINE + 1);

      // stride 4: all in one bank
      run_line(12'd8, 12'd4, -1, lf, ld, nw);
      chk(ld == LINE * (L + 2), "R5", "same-bank stride 4", ld, LINE * (L + 2));

      // stride 0: same word repeated, one bank
      run_line(12'd7, 12'd0, -1, lf, ld, nw);
      chk(ld == LINE * (L + 2), "R5", "stride 0", ld, LINE * (L + 2));

      // stride 2: banks 0,2,0,2
      run_line(12'd0, 12'd2, -1, lf, ld, nw);
      chk(ld == 2 * (L + 2) + 1, "R5", "stride 2 conflict", ld, 2 * (L + 2) + 1);

      // address wrap 4094,4095,0,1
      run_line(12'd4094, 12'd1, -1, lf, ld, nw);
      chk(ld == L + LINE + 1, "R4", "wrap line latency", ld, L + LINE + 1);
      chk(nw == LINE, "R4", "wrap word count", nw, LINE);

      // start while busy is ignored
      run_line(12'd100, 12'd1, 10, lf, ld, nw);
      chk(nw == LINE, "R9", "words with extra start", nw, LINE);
      chk(ld == L + LINE + 1, "R9", "latency with extra start", ld, L + LINE + 1);
      seen = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (busy || ret_valid) seen++;
      end
      chk(seen == 0, "R9", "no follow-up line", seen, 0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule